// File: doc/BRIEF.md
# Three-Wire Serial Bus Slave Interface

This block is the target side of a three-pin serial bus: an active-low select, a bus clock driven by the master, and a single bidirectional data line. It sits in front of a local register file. It turns each bus transaction into a single-cycle read or write strobe with a 5-bit register index. For a read, it returns the register contents one bit at a time on the data line.

A transaction is a 9-bit header followed by a 16-bit data frame. Both go most significant bit first. The header holds a 3-bit device address, a read flag and a register index. The slave compares the device address against its strapped parameter. It fetches a read register as soon as the header ends. It commits a write only after the last data bit. It then waits for the next header, so one select window can carry any number of transactions.

All three bus pins are brought into the system clock domain through synchronizer flops. A bus clock edge is found by comparing successive synchronized samples, so the bus clock must run well below the system clock. The data pin is split into an input, an output value and an output enable. The pad logic outside the block combines them into the tri-state line.

Top module: `serial3_slave`

## Requirements
- R1: After reset, bus_oe, reg_rd and reg_wr are all low and the slave waits for a 9-bit header.
- R2: Bits move only on a rising bus_clk edge seen while bus_sel_n is low; bus_clk activity while bus_sel_n is high produces no strobe and no drive.
- R3: The header arrives MSB first; header bits [8:6] are the device address, bit [5] is the read flag (1 = read) and bits [4:0] are the register index; only a header whose address equals DEV_ADDR is acted on.
- R4: For a matched read, reg_rd pulses for one cycle with reg_idx set right after the ninth header bit; bus_oe then rises, and the captured reg_rdata is presented MSB first on bus_dout, one bit per following rising bus_clk edge (bit 15 before the first data edge).
- R5: For a matched write, the 16 data bits are shifted in MSB first and reg_wr pulses once, with reg_idx and reg_wdata, only after the sixteenth data bit; no strobe occurs earlier in the frame.
- R6: After every data frame, the slave returns to header phase with bus_oe low, so back-to-back transactions work within one select window.
- R7: After a header whose address differs from DEV_ADDR, the slave issues no strobe and keeps bus_oe low for the rest of the select window, even if a matching header follows; the next select window starts fresh.
- R8: bus_oe is high only during the data frame of a matched read, and it falls within a few cycles of bus_sel_n going high, even in the middle of a frame.
- R9: Raising and lowering select again discards a partly received header or frame, and the next bits are read as a new header.
- R10: reg_rd and reg_wr are never high together, and each is high for exactly one cycle per transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel_n | input | 1 | Bus select, active low, asynchronous |
| bus_clk | input | 1 | Bus clock from the master, asynchronous |
| bus_din | input | 1 | Data line as seen at the pad |
| bus_dout | output | 1 | Value driven onto the data line |
| bus_oe | output | 1 | Output enable for the data line pad |
| reg_rd | output | 1 | One-cycle register read strobe |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_idx | output | 5 | Register index for the strobe |
| reg_wdata | output | DATA_W | Write data, valid with reg_wr |
| reg_rdata | input | DATA_W | Read data from the register file, sampled the cycle after reg_rd |

## Verification
A table of mixed reads and writes runs inside one select window. It uses all-zero, all-one, alternating and single-bit-at-each-end data words at the lowest and highest register index. This shows whether bit order, index decode and the return to header phase after each frame are right. A header is sent to each of the eight device addresses in turn, and only one of them must produce a strobe; this separates the address field from the read flag and index. Extra patterns cover bus clock edges with select high, a matching header after a mismatched one, a read cut short by select, and a partial header thrown away. These show whether the select pin truly resets the frame, or whether stale bits and the mismatch lock leak across windows.

// File: rtl/serial3_slave.sv
module serial3_slave #(
  parameter logic [2:0] DEV_ADDR    = 3'd1,
  parameter int         DATA_W      = 16,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel_n,
  input  logic              bus_clk,
  input  logic              bus_din,
  output logic              bus_dout,
  output logic              bus_oe,
  output logic              reg_rd,
  output logic              reg_wr,
  output logic [4:0]        reg_idx,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata
);
  localparam int            CW       = $clog2(DATA_W);
  localparam logic [CW-1:0] HDR_LAST = CW'(8);
  localparam logic [CW-1:0] DAT_LAST = CW'(DATA_W - 1);
  localparam logic [CW-1:0] ONE      = CW'(1);

  typedef enum logic {PH_HDR, PH_DATA} phase_t;

  logic [SYNC_STAGES-1:0] clk_sy, dat_sy, sel_sy;
  logic clk_prev;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      clk_sy   <= '0;
      dat_sy   <= '0;
      sel_sy   <= '1;
      clk_prev <= 1'b0;
    end else begin
      clk_sy   <= {clk_sy[SYNC_STAGES-2:0], bus_clk};
      dat_sy   <= {dat_sy[SYNC_STAGES-2:0], bus_din};
      sel_sy   <= {sel_sy[SYNC_STAGES-2:0], bus_sel_n};
      clk_prev <= clk_sy[SYNC_STAGES-1];
    end

  wire sclk   = clk_sy[SYNC_STAGES-1];
  wire sdat   = dat_sy[SYNC_STAGES-1];
  wire ssel_n = sel_sy[SYNC_STAGES-1];
  wire rise   = sclk & ~clk_prev & ~ssel_n;

  phase_t            phase;
  logic [CW-1:0]     cnt;
  logic [DATA_W-1:0] sh;
  logic              rd_mode, lock, oe_q, rd_q, wr_q;
  logic [4:0]        idx_q;
  logic [DATA_W-1:0] wdata_q;

  wire [8:0] hdr = {sh[7:0], sdat};
  wire       hit = (hdr[8:6] == DEV_ADDR);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase   <= PH_HDR;
      cnt     <= '0;
      sh      <= '0;
      rd_mode <= 1'b0;
      lock    <= 1'b0;
      oe_q    <= 1'b0;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      idx_q   <= '0;
      wdata_q <= '0;
    end else begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
      if (rd_q) sh <= reg_rdata;
      if (ssel_n) begin
        phase   <= PH_HDR;
        cnt     <= '0;
        sh      <= '0;
        rd_mode <= 1'b0;
        lock    <= 1'b0;
        oe_q    <= 1'b0;
      end else if (rise && !lock) begin
        if (phase == PH_HDR) begin
          if (cnt == HDR_LAST) begin
            cnt <= '0;
            sh  <= '0;
            if (hit) begin
              phase   <= PH_DATA;
              rd_mode <= hdr[5];
              idx_q   <= hdr[4:0];
              rd_q    <= hdr[5];
              oe_q    <= hdr[5];
            end else begin
              lock <= 1'b1;
            end
          end else begin
            sh  <= {sh[DATA_W-2:0], sdat};
            cnt <= cnt + ONE;
          end
        end else begin
          sh  <= {sh[DATA_W-2:0], rd_mode ? 1'b0 : sdat};
          cnt <= cnt + ONE;
          if (cnt == DAT_LAST) begin
            phase   <= PH_HDR;
            cnt     <= '0;
            sh      <= '0;
            oe_q    <= 1'b0;
            rd_mode <= 1'b0;
            if (!rd_mode) begin
              wr_q    <= 1'b1;
              wdata_q <= {sh[DATA_W-2:0], sdat};
            end
          end
        end
      end
    end

  assign bus_oe    = oe_q;
  assign bus_dout  = oe_q & sh[DATA_W-1];
  assign reg_rd    = rd_q;
  assign reg_wr    = wr_q;
  assign reg_idx   = idx_q;
  assign reg_wdata = wdata_q;

  assert_oe_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ssel_n |=> !bus_oe);
  assert_lock_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> (!reg_rd && !reg_wr && !bus_oe));
  assert_rd_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |-> bus_oe);
  assert_wr_on_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> $past(rise));
  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_wr));
  assert_rd_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);
  assert_wr_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);
endmodule

// File: tb/serial3_slave_tb.sv
module serial3_slave_tb;
  localparam logic [2:0] ME   = 3'd1;
  localparam int         HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel_n = 1'b1, bus_clk = 1'b0, bus_din = 1'b0;
  logic bus_dout, bus_oe, reg_rd, reg_wr;
  logic [4:0]  reg_idx;
  logic [15:0] reg_wdata, reg_rdata;

  always #5 clk = ~clk;

  serial3_slave #(.DEV_ADDR(ME)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel_n(bus_sel_n), .bus_clk(bus_clk),
    .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  function automatic logic [15:0] seed(int i);
    return 16'(i * 257) ^ 16'h5A00;
  endfunction

  logic [15:0] rf [32];
  logic [15:0] exp_mem [32];
  assign reg_rdata = rf[reg_idx];

  int rd_cnt = 0, wr_cnt = 0, both_cnt = 0, dbl_cnt = 0;
  logic oe_seen = 1'b0, prev_rd = 1'b0, prev_wr = 1'b0;
  logic [4:0]  last_rd_idx = '0, last_wr_idx = '0;
  logic [15:0] last_wd = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) rf[i] = seed(i);
    end else begin
      if (reg_rd) begin rd_cnt++; last_rd_idx = reg_idx; end
      if (reg_wr) begin wr_cnt++; last_wr_idx = reg_idx; last_wd = reg_wdata; rf[reg_idx] = reg_wdata; end
      if (reg_rd && reg_wr) both_cnt++;
      if ((reg_rd && prev_rd) || (reg_wr && prev_wr)) dbl_cnt++;
      if (bus_oe) oe_seen = 1'b1;
    end
    prev_rd = reg_rd;
    prev_wr = reg_wr;
  end

  int total = 0, bad = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(logic b);
    bus_din = b; bus_clk = 1'b0; tick(HALF);
    bus_clk = 1'b1; tick(HALF);
  endtask

  task automatic send_hdr(logic [2:0] a, logic r, logic [4:0] i);
    logic [8:0] h;
    h = {a, r, i};
    for (int k = 8; k >= 0; k--) send_bit(h[k]);
  endtask

  task automatic send_word(logic [15:0] w);
    for (int k = 15; k >= 0; k--) send_bit(w[k]);
  endtask

  task automatic recv_word(output logic [15:0] w);
    for (int k = 15; k >= 0; k--) begin
      bus_clk = 1'b0; tick(HALF);
      w[k] = bus_dout;
      bus_clk = 1'b1; tick(HALF);
    end
  endtask

  task automatic sel(logic v);
    bus_clk = 1'b0; bus_sel_n = v; tick(HALF);
  endtask

  localparam logic [21:0] VEC [8] = '{
    {1'b0, 5'd3,  16'hBEEF},
    {1'b0, 5'd31, 16'h8001},
    {1'b1, 5'd3,  16'h0000},
    {1'b0, 5'd0,  16'h0000},
    {1'b1, 5'd0,  16'h0000},
    {1'b0, 5'd0,  16'hFFFF},
    {1'b1, 5'd0,  16'h0000},
    {1'b1, 5'd31, 16'h0000}
  };

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    tick(150000);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    logic [15:0] w;
    int rc, wc;
    for (int i = 0; i < 32; i++) exp_mem[i] = seed(i);
    tick(5);
    rst_n = 1'b1;
    tick(5);

    check("R1 oe after reset", 32'(bus_oe), 32'd0);
    check("R1 no strobes after reset", 32'(rd_cnt + wr_cnt), 32'd0);

    sel(1'b0);
    for (int v = 0; v < 8; v++) begin
      rc = rd_cnt; wc = wr_cnt;
      if (VEC[v][21]) begin
        send_hdr(ME, 1'b1, VEC[v][20:16]);
        recv_word(w);
        check("R4 read data", 32'(w), 32'(exp_mem[VEC[v][20:16]]));
        check("R4 read strobe count", 32'(rd_cnt - rc), 32'd1);
        check("R4 read index", 32'(last_rd_idx), 32'(VEC[v][20:16]));
      end else begin
        send_hdr(ME, 1'b0, VEC[v][20:16]);
        send_word(VEC[v][15:0]);
        tick(2);
        exp_mem[VEC[v][20:16]] = VEC[v][15:0];
        check("R5 write strobe count", 32'(wr_cnt - wc), 32'd1);
        check("R5 write index", 32'(last_wr_idx), 32'(VEC[v][20:16]));
        check("R5 write data", 32'(last_wd), 32'(VEC[v][15:0]));
      end
      check("R6 back to header, oe low", 32'(bus_oe), 32'd0);
    end
    sel(1'b1);

    wc = wr_cnt;
    send_hdr(ME, 1'b0, 5'd7);
    send_word(16'h1357);
    tick(4);
    check("R2 edges with select high ignored", 32'(wr_cnt - wc), 32'd0);
    check("R2 register untouched", 32'(rf[7]), 32'(exp_mem[7]));

    wc = wr_cnt;
    sel(1'b0);
    send_hdr(ME, 1'b0, 5'd9);
    for (int k = 15; k >= 1; k--) send_bit(k[0]);
    check("R5 no strobe before last bit", 32'(wr_cnt - wc), 32'd0);
    send_bit(1'b0);
    tick(2);
    exp_mem[9] = 16'hAAAA;
    check("R5 strobe after last bit", 32'(wr_cnt - wc), 32'd1);
    check("R5 alternating data", 32'(last_wd), 32'hAAAA);
    sel(1'b1);

    wc = wr_cnt; rc = rd_cnt;
    for (int a = 0; a < 8; a++) begin
      sel(1'b0);
      send_hdr(3'(a), 1'b0, 5'(a));
      send_word(16'(16'hC000 + a));
      sel(1'b1);
    end
    check("R3 only own address writes", 32'(wr_cnt - wc), 32'd1);
    check("R3 decoded index", 32'(last_wr_idx), 32'(ME));
    check("R3 decoded data", 32'(last_wd), 32'(16'hC000 + ME));
    exp_mem[ME] = 16'hC000 + 16'(ME);

    wc = wr_cnt; rc = rd_cnt;
    oe_seen = 1'b0;
    sel(1'b0);
    send_hdr(3'd5, 1'b1, 5'd2);
    send_word(16'h1234);
    send_hdr(ME, 1'b0, 5'd2);
    send_word(16'h4321);
    send_hdr(ME, 1'b1, 5'd2);
    send_word(16'h0000);
    tick(2);
    check("R7 mismatch locks out strobes", 32'(wr_cnt - wc + rd_cnt - rc), 32'd0);
    check("R7 mismatch keeps line undriven", 32'(oe_seen), 32'd0);
    check("R7 register untouched", 32'(rf[2]), 32'(exp_mem[2]));
    sel(1'b1);
    sel(1'b0);
    send_hdr(ME, 1'b0, 5'd2);
    send_word(16'h4321);
    tick(2);
    exp_mem[2] = 16'h4321;
    check("R7 new window recovers", 32'(wr_cnt - wc), 32'd1);
    sel(1'b1);

    sel(1'b0);
    send_hdr(ME, 1'b1, 5'd3);
    tick(2);
    check("R8 oe during read frame", 32'(bus_oe), 32'd1);
    for (int k = 0; k < 4; k++) send_bit(1'b0);
    bus_sel_n = 1'b1;
    tick(5);
    check("R8 oe released by select", 32'(bus_oe), 32'd0);
    tick(HALF);

    wc = wr_cnt;
    sel(1'b0);
    for (int k = 0; k < 5; k++) send_bit(1'b1);
    sel(1'b1);
    sel(1'b0);
    send_hdr(ME, 1'b0, 5'd30);
    send_word(16'h0F0F);
    tick(2);
    exp_mem[30] = 16'h0F0F;
    check("R9 partial header discarded, strobe", 32'(wr_cnt - wc), 32'd1);
    check("R9 index after restart", 32'(last_wr_idx), 32'd30);
    send_hdr(ME, 1'b1, 5'd30);
    recv_word(w);
    check("R9 read back after restart", 32'(w), 32'h0F0F);
    sel(1'b1);

    check("R10 strobes never together", 32'(both_cnt), 32'd0);
    check("R10 strobes single cycle", 32'(dbl_cnt), 32'd0);

    finish_run();
  end
endmodule